// File: doc/BRIEF.md
# Bridge System Error Reporting Unit

This unit sits beside the transaction paths of a PCI-to-PCI bridge and decides when the bridge raises its primary system error line. It receives one-cycle event strobes from the posted-write and delayed-transaction logic. It also samples the secondary-bus system error input. Each event is passed through a global enable and then through one more gate: a per-event disable bit, the master-timeout enable, or the forwarding enable. A qualifying event drives the active-low primary output low for one clock.

The unit holds three retry counters, one each for the posted write, the delayed write and the delayed read. A counter turns too many target retries into a discard event, and that event goes through the same gates as the others. A sticky reason register records which events caused an assertion. Two sticky status bits record that a system error was signalled or received. Software reaches all of these through a small write port with a combinational read-back.

Top module: `brg_syserr_unit`

## Requirements
- R1: After reset the primary output is released (`p_serr_n` = 1, `p_serr_oe` = 0), and every register reads zero: control at address 0, mask at address 1, reason at address 2 and status at address 3.
- R2: While control bit 0 (global enable) is 0, no event drives `p_serr_n` low and no reason bit is set.
- R3: With the global enable set, each maskable event whose mask bit is 0 drives `p_serr_n` low in the cycle after its strobe and sets its reason bit. The bit positions, which are also the mask bit positions for bits 0 to 5, are: 0 posted-write target abort, 1 posted-write master abort, 2 posted-write retry discard, 3 posted-write target-bus parity error, 4 delayed-write retry discard, 5 delayed-read retry give-up.
- R4: Setting mask bit i (address 1, bits 5:0) suppresses event i entirely: there is no pulse and reason bit i stays clear.
- R5: A master timeout (reason bit 6) qualifies only when control bit 2 is set as well as the global enable. The mask register has no effect on it.
- R6: A falling edge on `sec_serr_n` while control bit 1 (forward enable) is set produces exactly one pulse, even when the input is held low. It also sets reason bit 7 and status bit 1 (received). With forward enable clear, it sets neither of these bits and produces no pulse.
- R7: Every pulse on `p_serr_n` sets status bit 0 (signalled).
- R8: Reason and status bits are sticky and are cleared by writing 1 to them. A bit that is set and cleared in the same cycle ends up set.
- R9: Each retry counter raises its discard event on the RETRY_LIMIT-th retry strobe since reset, since the last discard, or since the last clear. A clear strobe restarts the count. Retry index 0 is the posted write, 1 the delayed write and 2 the delayed read.
- R10: Events that arrive in the same cycle produce a single one-cycle pulse and set all of their reason bits together.
- R11: `p_serr_n` is low for exactly one cycle per qualifying cycle. `p_serr_oe` is always the inverse of `p_serr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pw_tabt | input | 1 | Target abort seen on a posted write |
| evt_pw_mabt | input | 1 | Master abort seen on a posted write |
| evt_pw_perr | input | 1 | Parity error reported on the target bus during a posted write |
| evt_dly_mto | input | 1 | Master timeout on a delayed transaction |
| retry_stb | input | 3 | Target retry received, one bit per retried path |
| retry_clr | input | 3 | Path completed or new transaction started; restarts its counter |
| sec_serr_n | input | 1 | Secondary-bus system error input, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| p_serr_n | output | 1 | Primary system error, active low |
| p_serr_oe | output | 1 | High while the primary line is pulled low; low means released |

## Verification
Each event strobe, retry strobe or secondary falling edge is registered once, so the pulse on `p_serr_n` and the updated reason and status bits are due one clock after the stimulus cycle. Read data follows `reg_addr` within the same cycle. The bench drives every input on the falling clock edge. It checks the pulse at the next falling edge, checks that the line is released one edge after that, and samples read data a moment after it sets the address. A retry discard happens on the strobe that reaches the limit, so the bench checks that the line stays high after each earlier strobe and goes low after that one.

// File: rtl/brg_serr_pkg.sv
// Package: shared constants and types of the bridge system error unit.
// Assumes: event index order matches the reason/mask bit layout in the brief.
package brg_serr_pkg;
    localparam int NUM_EVT    = 8;
    localparam int NUM_MASKED = 6;
    localparam int NUM_RETRY  = 3;
    localparam int REG_W      = 8;

    localparam int EV_PW_TABT = 0;
    localparam int EV_PW_MABT = 1;
    localparam int EV_PW_DISC = 2;
    localparam int EV_PW_PERR = 3;
    localparam int EV_DW_DISC = 4;
    localparam int EV_DR_DISC = 5;
    localparam int EV_MTO     = 6;
    localparam int EV_SEC_FWD = 7;

    localparam int RT_PW = 0;
    localparam int RT_DW = 1;
    localparam int RT_DR = 2;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_REASON = 2'd2;
    localparam logic [1:0] ADDR_STAT   = 2'd3;

    typedef struct packed {
        logic mto_en;
        logic fwd_en;
        logic serr_en;
    } ctrl_t;
endpackage

// File: rtl/brg_retry_cnt.sv
// Module: counts target retries of one bridge path and emits a one-cycle
// discard strobe on the LIMIT-th retry, then restarts from zero.
// Assumes: LIMIT >= 2; clr has priority over stb.
module brg_retry_cnt #(
    parameter int unsigned LIMIT = 32'd16777216
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic clr,
    output logic discard
);
    localparam int CW = $clog2(LIMIT);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == CW'(LIMIT - 1));
    assign discard = stb && !clr && at_last;

    // Advance, wrap or restart the retry count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) < LIMIT));

    assert_wrap_after_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> (cnt == '0));
endmodule

// File: rtl/brg_serr_regs.sv
// Module: software-visible control, mask, reason and status registers.
// Reason and status bits are sticky with write-1-to-clear; a set in the
// same cycle as a clear wins. Read data is combinational on the address.
module brg_serr_regs
    import brg_serr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen,
    input  logic [1:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [NUM_EVT-1:0] reason_set,
    input  logic               sig_set,
    input  logic               recv_set,
    output ctrl_t              ctrl,
    output logic [NUM_MASKED-1:0] mask,
    output logic [1:0]         stat,
    output logic [REG_W-1:0]   reg_rdata
);
    logic [NUM_EVT-1:0] reason;
    logic [NUM_EVT-1:0] reason_clr;
    logic [1:0]         stat_clr;
    logic               wr_reason;

    assign wr_reason  = reg_wen && (reg_addr == ADDR_REASON);
    assign reason_clr = wr_reason ? reg_wdata[NUM_EVT-1:0] : '0;
    assign stat_clr   = (reg_wen && (reg_addr == ADDR_STAT)) ? reg_wdata[1:0] : 2'b00;

    // Load control and mask registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            mask <= '0;
        end else if (reg_wen) begin
            if (reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[2:0]);
            if (reg_addr == ADDR_MASK) mask <= reg_wdata[NUM_MASKED-1:0];
        end
    end

    // Sticky reason and status bits with write-1-to-clear, set dominant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reason <= '0;
            stat   <= '0;
        end else begin
            reason <= (reason & ~reason_clr) | reason_set;
            stat   <= (stat & ~stat_clr) | {recv_set, sig_set};
        end
    end

    // Select read data by address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL:   reg_rdata[2:0] = ctrl;
            ADDR_MASK:   reg_rdata[NUM_MASKED-1:0] = mask;
            ADDR_REASON: reg_rdata[NUM_EVT-1:0] = reason;
            default:     reg_rdata[1:0] = stat;
        endcase
    end

    assert_reason_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_reason |=> ((reason & $past(reason)) == $past(reason)));
endmodule

// File: rtl/brg_syserr_unit.sv
// Module: top of the bridge system error unit. Qualifies each event through
// the global enable plus its own gate (mask bit, timeout enable or forward
// enable) and registers one primary pulse per qualifying cycle.
// Assumes: event inputs are one-cycle strobes synchronous to clk and
// sec_serr_n is already synchronised.
module brg_syserr_unit
    import brg_serr_pkg::*;
#(
    parameter int unsigned RETRY_LIMIT = 32'd16777216
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_pw_tabt,
    input  logic                 evt_pw_mabt,
    input  logic                 evt_pw_perr,
    input  logic                 evt_dly_mto,
    input  logic [NUM_RETRY-1:0] retry_stb,
    input  logic [NUM_RETRY-1:0] retry_clr,
    input  logic                 sec_serr_n,
    input  logic                 reg_wen,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 p_serr_n,
    output logic                 p_serr_oe
);
    ctrl_t                  ctrl;
    logic [NUM_MASKED-1:0]  mask;
    logic [1:0]             stat;
    logic [NUM_RETRY-1:0]   disc;
    logic [NUM_EVT-1:0]     evt;
    logic [NUM_EVT-1:0]     qual;
    logic                   sec_prev;
    logic                   sec_fall;
    logic                   pulse_q;

    for (genvar g = 0; g < NUM_RETRY; g++) begin : g_retry
        brg_retry_cnt #(.LIMIT(RETRY_LIMIT)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (retry_stb[g]),
            .clr     (retry_clr[g]),
            .discard (disc[g])
        );
    end

    // Remember the previous secondary line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_prev <= 1'b1;
        else        sec_prev <= sec_serr_n;
    end
    assign sec_fall = sec_prev && !sec_serr_n;

    // Gather raw events in reason-bit order.
    always_comb begin
        evt             = '0;
        evt[EV_PW_TABT] = evt_pw_tabt;
        evt[EV_PW_MABT] = evt_pw_mabt;
        evt[EV_PW_DISC] = disc[RT_PW];
        evt[EV_PW_PERR] = evt_pw_perr;
        evt[EV_DW_DISC] = disc[RT_DW];
        evt[EV_DR_DISC] = disc[RT_DR];
        evt[EV_MTO]     = evt_dly_mto;
        evt[EV_SEC_FWD] = sec_fall;
    end

    for (genvar i = 0; i < NUM_MASKED; i++) begin : g_masked
        assign qual[i] = ctrl.serr_en && evt[i] && !mask[i];
    end
    assign qual[EV_MTO]     = ctrl.serr_en && evt[EV_MTO] && ctrl.mto_en;
    assign qual[EV_SEC_FWD] = ctrl.serr_en && evt[EV_SEC_FWD] && ctrl.fwd_en;

    // Register one primary pulse per qualifying cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= |qual;
    end

    assign p_serr_n  = !pulse_q;
    assign p_serr_oe = pulse_q;

    brg_serr_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reason_set (qual),
        .sig_set    (|qual),
        .recv_set   (sec_fall && ctrl.fwd_en),
        .ctrl       (ctrl),
        .mask       (mask),
        .stat       (stat),
        .reg_rdata  (reg_rdata)
    );

    assert_global_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> $past(ctrl.serr_en));

    assert_signalled_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> stat[0]);

    assert_pulse_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !p_serr_n |-> $past(|qual));

    assert_recv_needs_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> $past(ctrl.fwd_en));
endmodule

// File: tb/brg_syserr_unit_bench.sv
// Bench: vector table for the gating paths, then directed tests for reset,
// forwarding, sticky clears, retry limits and simultaneous events.
module brg_syserr_unit_bench;
    localparam int unsigned LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_pw_tabt = 0, evt_pw_mabt = 0, evt_pw_perr = 0, evt_dly_mto = 0;
    logic [2:0] retry_stb = '0, retry_clr = '0;
    logic       sec_serr_n = 1'b1;
    logic       reg_wen = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       p_serr_n, p_serr_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    brg_syserr_unit #(.RETRY_LIMIT(LIM)) u_brg_syserr_unit (
        .clk(clk), .rst_n(rst_n),
        .evt_pw_tabt(evt_pw_tabt), .evt_pw_mabt(evt_pw_mabt),
        .evt_pw_perr(evt_pw_perr), .evt_dly_mto(evt_dly_mto),
        .retry_stb(retry_stb), .retry_clr(retry_clr),
        .sec_serr_n(sec_serr_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .p_serr_n(p_serr_n), .p_serr_oe(p_serr_oe)
    );

    // {ctrl[2:0], mask[5:0], events{tabt,mabt,perr,mto}, pulse, reason[7:0]}
    localparam logic [21:0] VEC [12] = '{
        {3'b001, 6'h00, 4'b1000, 1'b1, 8'h01},  // R3 target abort
        {3'b001, 6'h00, 4'b0100, 1'b1, 8'h02},  // R3 master abort
        {3'b001, 6'h00, 4'b0010, 1'b1, 8'h08},  // R3 parity
        {3'b000, 6'h00, 4'b1000, 1'b0, 8'h00},  // R2 disabled
        {3'b001, 6'h01, 4'b1000, 1'b0, 8'h00},  // R4 masked
        {3'b001, 6'h01, 4'b1100, 1'b1, 8'h02},  // R4 one of two masked
        {3'b001, 6'h00, 4'b0001, 1'b0, 8'h00},  // R5 timeout enable off
        {3'b101, 6'h00, 4'b0001, 1'b1, 8'h40},  // R5 timeout
        {3'b101, 6'h3F, 4'b0001, 1'b1, 8'h40},  // R5 mask ignored
        {3'b100, 6'h00, 4'b0001, 1'b0, 8'h00},  // R2 timeout without global
        {3'b101, 6'h00, 4'b1111, 1'b1, 8'h4B},  // R10 all together
        {3'b001, 6'h08, 4'b0010, 1'b0, 8'h00}   // R4 parity masked
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h03);
    endtask

    // One retry strobe on path p; returns the line level one edge later.
    task automatic retry(input int p, output logic lvl);
        retry_stb[p] = 1'b1;
        @(negedge clk);
        retry_stb = '0;
        lvl = p_serr_n;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic       lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 p_serr_n", {7'd0, p_serr_n}, 8'h01);
        check("R1 p_serr_oe", {7'd0, p_serr_oe}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 register zero", d, 8'h00);
        end

        // Vector table for gating paths
        for (int v = 0; v < 12; v++) begin
            wr(2'd0, {5'd0, VEC[v][21:19]});
            wr(2'd1, {2'd0, VEC[v][18:13]});
            clear_all();
            {evt_pw_tabt, evt_pw_mabt, evt_pw_perr, evt_dly_mto} = VEC[v][12:9];
            @(negedge clk);
            {evt_pw_tabt, evt_pw_mabt, evt_pw_perr, evt_dly_mto} = 4'b0000;
            check("R3 pulse per vector", {7'd0, p_serr_n}, {7'd0, !VEC[v][8]});
            check("R11 oe inverse", {7'd0, p_serr_oe}, {7'd0, !p_serr_n});
            @(negedge clk);
            check("R11 released after one cycle", {7'd0, p_serr_n}, 8'h01);
            rd(2'd2, d);
            check("R3 reason bits", d, VEC[v][7:0]);
            rd(2'd3, d);
            check("R7 signalled bit", d, {7'd0, VEC[v][8]});
        end
        wr(2'd1, 8'h00);

        // R6 forwarding with line held low
        wr(2'd0, 8'h03);
        clear_all();
        sec_serr_n = 1'b0;
        @(negedge clk);
        check("R6 forward pulse", {7'd0, p_serr_n}, 8'h00);
        @(negedge clk);
        check("R6 single pulse while held", {7'd0, p_serr_n}, 8'h01);
        sec_serr_n = 1'b1;
        rd(2'd3, d);
        check("R6 received and signalled", d, 8'h03);
        rd(2'd2, d);
        check("R6 reason bit 7", d, 8'h80);

        // R6 forward enable off
        wr(2'd0, 8'h01);
        clear_all();
        sec_serr_n = 1'b0;
        @(negedge clk);
        check("R6 no pulse without forward", {7'd0, p_serr_n}, 8'h01);
        sec_serr_n = 1'b1;
        @(negedge clk);
        rd(2'd3, d);
        check("R6 no received bit", d, 8'h00);

        // R8 partial write-1-clear
        evt_pw_tabt = 1'b1; evt_pw_mabt = 1'b1;
        @(negedge clk);
        evt_pw_tabt = 1'b0; evt_pw_mabt = 1'b0;
        wr(2'd2, 8'h01);
        rd(2'd2, d);
        check("R8 only written bit cleared", d, 8'h02);
        // R8 set wins over clear in the same cycle
        evt_pw_tabt = 1'b1;
        reg_wen = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wen = 1'b0; evt_pw_tabt = 1'b0;
        rd(2'd2, d);
        check("R8 set dominates clear", d, 8'h03);

        // R9 retry limit on each path
        for (int p = 0; p < 3; p++) begin
            clear_all();
            for (int k = 0; k < int'(LIM) - 1; k++) begin
                retry(p, lvl);
                check("R9 no discard before limit", {7'd0, lvl}, 8'h01);
            end
            retry(p, lvl);
            check("R9 discard at limit", {7'd0, lvl}, 8'h00);
            @(negedge clk);
            rd(2'd2, d);
            check("R9 discard reason bit", d, (p == 0) ? 8'h04 : (p == 1) ? 8'h10 : 8'h20);
        end

        // R9 clear restarts the count
        clear_all();
        for (int k = 0; k < int'(LIM) - 1; k++) retry(1, lvl);
        retry_clr[1] = 1'b1;
        @(negedge clk);
        retry_clr = '0;
        for (int k = 0; k < int'(LIM) - 1; k++) begin
            retry(1, lvl);
            check("R9 count restarted by clear", {7'd0, lvl}, 8'h01);
        end
        retry(1, lvl);
        check("R9 discard after restart", {7'd0, lvl}, 8'h00);

        // R10 secondary edge and abort in the same cycle
        @(negedge clk);
        wr(2'd0, 8'h03);
        clear_all();
        sec_serr_n = 1'b0; evt_pw_tabt = 1'b1;
        @(negedge clk);
        sec_serr_n = 1'b1; evt_pw_tabt = 1'b0;
        check("R10 combined pulse", {7'd0, p_serr_n}, 8'h00);
        @(negedge clk);
        check("R10 one pulse only", {7'd0, p_serr_n}, 8'h01);
        rd(2'd2, d);
        check("R10 both reasons", d, 8'h81);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule